// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block sits next to a simple 32-bit processor core. It owns the privilege state: one bit selects kernel or user mode, and a second bit enables external interrupts. It watches for three kinds of control-flow events: a privilege violation (an exception), a software trap that carries a service number, and latched external interrupt requests. When one of these is taken, the block saves the current PC and the mode and enable bits. It enters kernel mode with interrupts masked, and on the next cycle it sends the fetch stage a redirect to the handler address held in an internal vector table.

Kernel code programs the block through a single write port. The selector picks one of four targets: a vector table entry, the live status bits, the saved PC, or the acknowledge of one pending interrupt. A return-from-trap strobe sends fetch back to the saved PC, which kernel code may have replaced to switch contexts. In the same cycle it restores the saved mode and enable bits. Interrupt requests stay latched until kernel code acknowledges each one by index, so masking interrupts never loses a request.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the block is in kernel mode with interrupts disabled, no redirect, no pending interrupt, saved PC zero and cause zero.
- R2: When an event is taken, after the next clock edge `kernel_mode`=1, `irq_en`=0, `redirect`=1 and `saved_pc` holds the `cur_pc` of the event cycle. The previous mode and enable bits are kept for return.
- R3: The redirect PC equals the vector table entry at the event's cause index. The cause index is 0 for a privilege violation, 1+`trap_svc` for a trap, and NSVC+1+i for external interrupt i. `cause` reports the same index.
- R4: Fixed priority decides between simultaneous causes. A privilege violation wins over a trap, and a trap wins over an interrupt. Among pending interrupts, the lowest index wins.
- R5: A pending interrupt is taken only while `irq_en`=1. While interrupts are disabled it stays set in `irq_pending` and causes no redirect.
- R6: A pending bit is set by a request pulse. It is cleared only by a kernel write with `cfg_sel`=3 and `cfg_idx` equal to the interrupt index. A request arriving in the same cycle as the clear leaves the bit set.
- R7: In user mode, `cfg_we`, `priv_op` or `rett` raises a privilege violation (cause 0). The attempted write or return has no effect.
- R8: `rett` in kernel mode with no event taken redirects to `saved_pc`. At the same edge it restores the saved mode and enable bits.
- R9: A kernel write with `cfg_sel`=2 replaces `saved_pc`, so the next return resumes at that address.
- R10: A kernel write with `cfg_sel`=1 sets mode from `cfg_data[0]` (1 = kernel) and interrupt enable from `cfg_data[1]`. `cfg_sel`=0 writes vector entry `cfg_idx` (indexes at or above the table size are dropped).
- R11: A taken event overrides a coincident kernel write or return, which then has no effect. A return overrides a coincident write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NIRQ | External interrupt request pulses |
| trap_req | input | 1 | Trap instruction strobe |
| trap_svc | input | $clog2(NSVC) | Service number of the trap |
| priv_op | input | 1 | Core is executing a privileged instruction |
| rett | input | 1 | Return-from-trap strobe |
| cur_pc | input | XLEN | PC of the instruction in the event cycle |
| cfg_we | input | 1 | Kernel configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 vector, 1 status, 2 saved PC, 3 interrupt acknowledge |
| cfg_idx | input | $clog2(1+NSVC+NIRQ) | Vector index or interrupt index |
| cfg_data | input | XLEN | Write data |
| redirect | output | 1 | Fetch redirect valid |
| redirect_pc | output | XLEN | Fetch redirect target |
| cause | output | $clog2(1+NSVC+NIRQ) | Index of the last taken event |
| kernel_mode | output | 1 | Current mode, 1 = kernel |
| irq_en | output | 1 | Current interrupt enable |
| irq_pending | output | NIRQ | Latched interrupt requests |
| saved_pc | output | XLEN | Saved return PC |

## Verification
The bench sets several causes in the same cycle to probe the priority order. A wrong order would vector a user-mode trap with a privileged side effect to the trap handler and not to the violation entry, or would service interrupt 2 ahead of interrupt 1. It holds requests while interrupts are masked and acknowledges them one at a time. A design that cleared pending bits when it took the event, or on any acknowledge, would lose the second request. Privileged writes are attempted from user mode, and a kernel write is aimed at the same cycle as a taken interrupt. Both leave the vector table untouched, which later violations reveal through the redirect address. A return after the saved PC has been rewritten shows whether the old PC leaks through, or whether the mode and enable bits come back a cycle late.

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl #(
  parameter int XLEN = 32,
  parameter int NIRQ = 4,
  parameter int NSVC = 4,
  localparam int NVEC = 1 + NSVC + NIRQ,
  localparam int VW = $clog2(NVEC),
  localparam int SW = $clog2(NSVC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            trap_req,
  input  logic [SW-1:0]   trap_svc,
  input  logic            priv_op,
  input  logic            rett,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [VW-1:0]   cfg_idx,
  input  logic [XLEN-1:0] cfg_data,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic [VW-1:0]   cause,
  output logic            kernel_mode,
  output logic            irq_en,
  output logic [NIRQ-1:0] irq_pending,
  output logic [XLEN-1:0] saved_pc
);

  logic [XLEN-1:0] vec [NVEC];
  logic            prev_mode, prev_ie;
  logic            violation, irq_hit, ev, rett_ok, wr_ok;
  logic [VW-1:0]   irq_cause, ev_cause;
  logic [NIRQ-1:0] ack;

  assign violation = ~kernel_mode & (cfg_we | priv_op | rett);
  assign irq_hit   = irq_en & (|irq_pending);
  assign ev        = violation | trap_req | irq_hit;
  assign rett_ok   = rett & kernel_mode & ~ev;
  assign wr_ok     = cfg_we & kernel_mode & ~ev & ~rett;

  always_comb begin
    irq_cause = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (irq_pending[i]) irq_cause = VW'(NSVC + 1 + i);
  end

  assign ev_cause = violation ? '0 :
                    trap_req  ? VW'(trap_svc) + VW'(1) : irq_cause;

  genvar g;
  generate
    for (g = 0; g < NIRQ; g++) begin : g_ack
      assign ack[g] = wr_ok && cfg_sel == 2'd3 && cfg_idx == VW'(g);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pending <= '0;
    else        irq_pending <= (irq_pending & ~ack) | irq_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) vec[i] <= '0;
    end else if (wr_ok && cfg_sel == 2'd0 && 32'(cfg_idx) < NVEC) begin
      vec[cfg_idx] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kernel_mode <= 1'b1;
      irq_en      <= 1'b0;
      prev_mode   <= 1'b1;
      prev_ie     <= 1'b0;
      saved_pc    <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
      cause       <= '0;
    end else if (ev) begin
      prev_mode   <= kernel_mode;
      prev_ie     <= irq_en;
      kernel_mode <= 1'b1;
      irq_en      <= 1'b0;
      saved_pc    <= cur_pc;
      redirect    <= 1'b1;
      redirect_pc <= vec[ev_cause];
      cause       <= ev_cause;
    end else if (rett_ok) begin
      kernel_mode <= prev_mode;
      irq_en      <= prev_ie;
      redirect    <= 1'b1;
      redirect_pc <= saved_pc;
    end else begin
      redirect <= 1'b0;
      if (wr_ok && cfg_sel == 2'd1) begin
        kernel_mode <= cfg_data[0];
        irq_en      <= cfg_data[1];
      end
      if (wr_ok && cfg_sel == 2'd2) saved_pc <= cfg_data;
    end
  end

  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> kernel_mode && !irq_en && redirect && saved_pc == $past(cur_pc));

  p_viol_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kernel_mode && (cfg_we || priv_op || rett)) |=> redirect && cause == '0 && kernel_mode);

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !trap_req && !rett && !violation) |=> !redirect);

  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_pending & ~irq_req & ~ack)) |=> (|irq_pending));

  p_rett_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rett_ok |=> redirect && redirect_pc == $past(saved_pc)
               && kernel_mode == $past(prev_mode) && irq_en == $past(prev_ie));

endmodule

// File: tb/priv_trap_ctrl_test.sv
module priv_trap_ctrl_test;
  localparam int XLEN = 32, NIRQ = 4, NSVC = 4;
  localparam int NVEC = 1 + NSVC + NIRQ;
  localparam int VW = $clog2(NVEC), SW = $clog2(NSVC);

  logic clk = 0, rst_n = 0;
  logic [NIRQ-1:0] irq_req;
  logic trap_req, priv_op, rett, cfg_we;
  logic [SW-1:0] trap_svc;
  logic [XLEN-1:0] cur_pc, cfg_data;
  logic [1:0] cfg_sel;
  logic [VW-1:0] cfg_idx;
  logic redirect, kernel_mode, irq_en;
  logic [XLEN-1:0] redirect_pc, saved_pc;
  logic [VW-1:0] cause;
  logic [NIRQ-1:0] irq_pending;

  always #2 clk = ~clk;

  priv_trap_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ), .NSVC(NSVC)) uut (
    .clk, .rst_n, .irq_req, .trap_req, .trap_svc, .priv_op, .rett, .cur_pc,
    .cfg_we, .cfg_sel, .cfg_idx, .cfg_data, .redirect, .redirect_pc, .cause,
    .kernel_mode, .irq_en, .irq_pending, .saved_pc);

  int total = 0, bad = 0;
  logic m_mode, m_ie, m_pmode, m_pie, m_red;
  logic [XLEN-1:0] m_epc, m_rpc;
  logic [XLEN-1:0] m_vec [NVEC];
  logic [NIRQ-1:0] m_pend;
  int m_cause;

  task automatic quiet();
    irq_req = '0; trap_req = 0; trap_svc = '0; priv_op = 0; rett = 0;
    cfg_we = 0; cfg_sel = '0; cfg_idx = '0; cfg_data = '0;
    cur_pc = $urandom;
  endtask

  task automatic model_next();
    logic viol, hit;
    int c;
    logic [NIRQ-1:0] ack;
    viol = !m_mode && (cfg_we || priv_op || rett);
    hit = m_ie && (m_pend != 0);
    c = 0;
    if (!viol && trap_req) c = 1 + int'(trap_svc);
    else if (!viol && hit)
      for (int i = NIRQ - 1; i >= 0; i--) if (m_pend[i]) c = NSVC + 1 + i;
    ack = '0;
    if (viol || trap_req || hit) begin
      m_pmode = m_mode; m_pie = m_ie; m_mode = 1; m_ie = 0;
      m_epc = cur_pc; m_red = 1; m_rpc = m_vec[c]; m_cause = c;
    end else if (rett) begin
      m_red = 1; m_rpc = m_epc; m_mode = m_pmode; m_ie = m_pie;
    end else begin
      m_red = 0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: if (int'(cfg_idx) < NVEC) m_vec[cfg_idx] = cfg_data;
          2'd1: begin m_mode = cfg_data[0]; m_ie = cfg_data[1]; end
          2'd2: m_epc = cfg_data;
          default: if (int'(cfg_idx) < NIRQ) ack[cfg_idx] = 1'b1;
        endcase
      end
    end
    m_pend = (m_pend & ~ack) | irq_req;
  endtask

  task automatic check(string tag);
    total++;
    if (redirect !== m_red || (m_red && redirect_pc !== m_rpc) || cause !== VW'(m_cause) ||
        kernel_mode !== m_mode || irq_en !== m_ie || irq_pending !== m_pend || saved_pc !== m_epc) begin
      bad++;
      $display("FAIL %s: got red=%0b pc=%h cause=%0d k=%0b ie=%0b pend=%b epc=%h exp red=%0b pc=%h cause=%0d k=%0b ie=%0b pend=%b epc=%h",
        tag, redirect, redirect_pc, cause, kernel_mode, irq_en, irq_pending, saved_pc,
        m_red, m_rpc, m_cause, m_mode, m_ie, m_pend, m_epc);
    end
  endtask

  task automatic step(string tag);
    model_next();
    @(posedge clk);
    @(negedge clk);
    check(tag);
    quiet();
  endtask

  task automatic wr(logic [1:0] sel, int idx, logic [XLEN-1:0] d, string tag);
    cfg_we = 1; cfg_sel = sel; cfg_idx = VW'(idx); cfg_data = d;
    step(tag);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    quiet();
    m_mode = 1; m_ie = 0; m_pmode = 1; m_pie = 0; m_red = 0;
    m_epc = '0; m_rpc = '0; m_pend = '0; m_cause = 0;
    for (int i = 0; i < NVEC; i++) m_vec[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state");

    for (int i = 0; i < NVEC; i++) wr(2'd0, i, 32'h1000 + 32'(i) * 16, "R10 vector write");
    wr(2'd0, 12, 32'hBAD0, "R10 out-of-range vector write dropped");
    wr(2'd1, 0, 32'h2, "R10 status write to user, ie on");

    trap_req = 1; trap_svc = 2; cur_pc = 32'h400; step("R2 R3 trap entry");
    rett = 1; step("R8 return restores user and ie");

    irq_req = 4'b0110; step("R6 request latched");
    step("R4 lowest pending interrupt taken");
    step("R5 masked in handler, pending kept");
    wr(2'd3, 1, 0, "R6 acknowledge one index");
    wr(2'd2, 0, 32'h800, "R9 saved pc rewrite");
    rett = 1; step("R9 return to rewritten pc");
    step("R5 second pending taken after enable");
    wr(2'd3, 2, 0, "R6 acknowledge second");
    rett = 1; step("R8 return");

    wr(2'd0, 0, 32'hDEAD, "R7 user vector write faults");
    rett = 1; step("R8 return");
    wr(2'd1, 0, 32'h1, "R7 user status write faults");
    rett = 1; step("R8 return");
    trap_req = 1; priv_op = 1; trap_svc = 1; step("R4 violation beats trap");
    rett = 1; step("R8 return");

    irq_req = 4'b0001; step("R6 request latched");
    trap_req = 1; trap_svc = 3; step("R4 trap beats interrupt");
    irq_req = 4'b0001; cfg_we = 1; cfg_sel = 2'd3; cfg_idx = 0; step("R6 request wins over clear");
    wr(2'd3, 0, 0, "R6 clear");
    rett = 1; step("R8 return");

    trap_req = 1; trap_svc = 0; step("R2 trap to kernel");
    wr(2'd1, 0, 32'h3, "R10 kernel with ie on");
    irq_req = 4'b1000; step("R6 request latched");
    wr(2'd0, 0, 32'hDEAD, "R11 event overrides write");
    wr(2'd3, 3, 0, "R6 clear");
    rett = 1; cfg_we = 1; cfg_sel = 2'd2; cfg_data = 32'h55; step("R11 return overrides write");
    wr(2'd1, 0, 32'h0, "R10 to user, ie off");
    priv_op = 1; step("R11 vector zero unchanged");

    for (int n = 0; n < 4000; n++) begin
      irq_req = ($urandom % 8 == 0) ? NIRQ'($urandom) : '0;
      trap_req = ($urandom % 10 == 0);
      trap_svc = SW'($urandom);
      priv_op = ($urandom % 20 == 0);
      rett = ($urandom % 8 == 0);
      cfg_we = ($urandom % 4 == 0);
      cfg_sel = 2'($urandom);
      cfg_idx = VW'($urandom);
      cfg_data = $urandom;
      step("R4 random mix");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule